// File: doc/BRIEF.md
# I2C DAC Write-Command Receiver

This block is the bus-facing front end of a 12-bit digital-to-analog converter that also keeps a non-volatile copy of its setting. It watches a two-wire serial bus (SCL, SDA) on the system clock, finds START and STOP conditions and answers only to its own 7-bit address. That address is a fixed four-bit device code followed by three bits set by strap inputs. Once addressed for a write, it takes a command byte and two data bytes. After it acknowledges the last of these, it loads a 12-bit code and two power-down bits into the DAC register that drives the converter.

One command code loads only the DAC register. A second code loads the same register and also starts a non-volatile write. That write is modelled by a clock counter of configurable length, and while it runs the `ready_o` output is low. During this time the block refuses any command by not acknowledging it. If the master sends no STOP, it may keep sending further groups of command plus two data bytes, and each complete group is applied as a new command. A START or STOP anywhere throws away a partly received group.

The slave answers by asserting an open-drain enable during the acknowledge bit. The bus pins are passed through a synchronizer, so the system clock must run many times faster than SCL.

Top module: `dac_i2c_write_rx`

## Requirements
- R1: After synchronous reset, `sda_oe_o` is 0, `ready_o` is 1, `dac_code_o` is 0 and `dac_pd_o` is 0.
- R2: The first byte after a START (MSB first) is acknowledged only when its bits [7:4] are 4'b1100, bits [3:1] equal `dev_sel_i` and bit 0 (read/write) is 0. Acknowledging means `sda_oe_o` is 1 throughout the following SCL high phase. For any other first byte, nothing is acknowledged until the next START.
- R3: In the second byte, bits [7:5] are the command code and bits [2:1] are the power-down field (bit 2 maps to `dac_pd_o[1]`). Bits 4, 3 and 0 are ignored. The byte is acknowledged whenever `ready_o` is 1.
- R4: The third byte gives code bits [11:4] and the fourth byte's bits [7:4] give code bits [3:0]. The fourth byte's bits [3:0] have no effect. With command 3'b010, `dac_code_o` and `dac_pd_o` take the new values after the SCL fall that ends the fourth byte's acknowledge.
- R5: Command 3'b011 updates the DAC register as in R4. In the same clock, `ready_o` goes low, and it stays low for exactly NV_CYCLES clocks.
- R6: While `ready_o` is low, a command byte is not acknowledged. Its group is discarded and the DAC register does not change.
- R7: Without a STOP, each further complete group of command byte plus two data bytes is applied on its own fourth-byte acknowledge.
- R8: A command code other than 3'b010 or 3'b011 is acknowledged with its data bytes, but it changes neither the DAC register nor `ready_o`.
- R9: A START or STOP before the fourth-byte acknowledge completes discards the partial group. A START returns the block to waiting for an address byte.
- R10: Each output responds exactly three system clocks after the bus edge that causes it: two synchronizer stages plus one state register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin (wired-AND value) |
| dev_sel_i | input | 3 | Strap value for the low three address bits |
| sda_oe_o | output | 1 | Pull SDA low when 1 (acknowledge) |
| dac_code_o | output | 12 | DAC register code |
| dac_pd_o | output | 2 | DAC register power-down field |
| ready_o | output | 1 | High when idle, low during the modelled non-volatile write |

## Verification
A wrong frame state (a bit count off by one, a wrong byte slot, or a missed abort) shows up at `sda_oe_o` within one SCL bit. The acknowledge then lands in the wrong bit time or disappears, three clocks after the offending SCL fall. A wrong decode or capture shows up as a wrong `dac_code_o` or `dac_pd_o` three clocks after the fourth acknowledge ends. A timer fault shows up as `ready_o` going low in the wrong clock or staying low for a length other than NV_CYCLES. Because the bench predicts all four outputs every clock, any of these faults is flagged on the first clock it appears.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
  localparam int DAC_W  = 12;
  localparam int PD_W   = 2;
  localparam int SEL_W  = 3;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 3;
  localparam int BCNT_W = $clog2(BYTE_W + 1);
  localparam int HI_W   = DAC_W - (BYTE_W / 2);

  localparam logic [3:0]       DEV_CODE   = 4'b1100;
  localparam logic [CMD_W-1:0] CMD_DAC    = 3'b010;
  localparam logic [CMD_W-1:0] CMD_DAC_NV = 3'b011;

  typedef enum logic [1:0] {PH_IDLE, PH_BITS, PH_ACK, PH_SKIP} phase_t;
  typedef enum logic [1:0] {SL_ADDR, SL_CMD, SL_HI, SL_LO} slot_t;
endpackage

// File: rtl/dacw_bus_sync.sv
module dacw_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_q, sda_q, scl_now;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            scl_pipe[g] <= 1'b1;
            sda_pipe[g] <= 1'b1;
          end else begin
            scl_pipe[g] <= scl_i;
            sda_pipe[g] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            scl_pipe[g] <= 1'b1;
            sda_pipe[g] <= 1'b1;
          end else begin
            scl_pipe[g] <= scl_pipe[g-1];
            sda_pipe[g] <= sda_pipe[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_pipe[STAGES-1];
      sda_q <= sda_pipe[STAGES-1];
    end
  end

  assign scl_now   = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_now & ~scl_q;
  assign scl_fall  = ~scl_now & scl_q;
  assign start_evt = scl_now & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_now & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/dacw_nv_timer.sv
module dacw_nv_timer #(
  parameter int NV_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = (NV_CYCLES > 1) ? $clog2(NV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(NV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= LOAD;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5: a run must not end before the counter drains
  assert_busy_drain_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q != '0) |=> busy);
endmodule

// File: rtl/dacw_frame_fsm.sv
module dacw_frame_fsm
  import dacw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [SEL_W-1:0] dev_sel,
  input  logic             busy,
  output logic             sda_oe,
  output logic [DAC_W-1:0] dac_code,
  output logic [PD_W-1:0]  dac_pd,
  output logic             nv_go
);
  phase_t            phase;
  slot_t             slot;
  logic [BCNT_W-1:0] bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [CMD_W-1:0]  cmd_q;
  logic [PD_W-1:0]   pd_q;
  logic [BYTE_W-1:0] hi_q;
  logic              byte_ok, byte_done, group_end, cmd_known;
  slot_t             slot_nx;

  always_comb begin
    case (slot)
      SL_ADDR: byte_ok = (shreg[7:1] == {DEV_CODE, dev_sel}) && !shreg[0];
      SL_CMD:  byte_ok = !busy;
      default: byte_ok = 1'b1;
    endcase
  end

  always_comb begin
    case (slot)
      SL_ADDR: slot_nx = SL_CMD;
      SL_CMD:  slot_nx = SL_HI;
      SL_HI:   slot_nx = SL_LO;
      default: slot_nx = SL_CMD;
    endcase
  end

  assign byte_done = (phase == PH_BITS) && scl_fall && (bit_cnt == BCNT_W'(BYTE_W));
  assign group_end = (phase == PH_ACK) && scl_fall && (slot == SL_LO);
  assign cmd_known = (cmd_q == CMD_DAC) || (cmd_q == CMD_DAC_NV);
  assign nv_go     = group_end && (cmd_q == CMD_DAC_NV) && !start_evt && !stop_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      slot     <= SL_ADDR;
      bit_cnt  <= '0;
      shreg    <= '0;
      cmd_q    <= '0;
      pd_q     <= '0;
      hi_q     <= '0;
      sda_oe   <= 1'b0;
      dac_code <= '0;
      dac_pd   <= '0;
    end else if (start_evt) begin
      phase   <= PH_BITS;
      slot    <= SL_ADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_evt) begin
      phase  <= PH_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (phase)
        PH_BITS: begin
          if (scl_rise) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            if (byte_ok) begin
              phase  <= PH_ACK;
              sda_oe <= 1'b1;
              if (slot == SL_CMD) begin
                cmd_q <= shreg[7:5];
                pd_q  <= shreg[2:1];
              end
              if (slot == SL_HI) hi_q <= shreg;
            end else begin
              phase <= PH_SKIP;
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            sda_oe  <= 1'b0;
            phase   <= PH_BITS;
            bit_cnt <= '0;
            slot    <= slot_nx;
            if (group_end && cmd_known) begin
              dac_code <= {hi_q, shreg[BYTE_W-1:BYTE_W-(DAC_W-HI_W)]};
              dac_pd   <= pd_q;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R2: the acknowledge drive only moves on an SCL fall or a bus condition
  assert_oe_edge_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall || start_evt || stop_evt));
  // R4: the DAC register only changes on an SCL fall
  assert_dac_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(dac_code) || !$stable(dac_pd)) |-> $past(scl_fall));
  // R2: the bit counter never runs past one byte
  assert_bitcnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= BCNT_W'(BYTE_W));
endmodule

// File: rtl/dac_i2c_write_rx.sv
module dac_i2c_write_rx
  import dacw_pkg::*;
#(
  parameter int NV_CYCLES   = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] dev_sel_i,
  output logic             sda_oe_o,
  output logic [DAC_W-1:0] dac_code_o,
  output logic [PD_W-1:0]  dac_pd_o,
  output logic             ready_o
);
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic busy, nv_go;

  dacw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  dacw_frame_fsm u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .dev_sel(dev_sel_i), .busy(busy), .sda_oe(sda_oe_o),
    .dac_code(dac_code_o), .dac_pd(dac_pd_o), .nv_go(nv_go)
  );

  dacw_nv_timer #(.NV_CYCLES(NV_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(nv_go), .busy(busy)
  );

  assign ready_o = ~busy;

  // R6: the DAC register is frozen while the write is running
  assert_busy_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    $past(!ready_o) |-> ($stable(dac_code_o) && $stable(dac_pd_o)));
  // R5: ready only falls right after a write-with-store group ends
  assert_ready_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_o) |-> $past(nv_go));
  // R8: ready stays high when no store is requested
  assert_ready_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(ready_o) && !$past(nv_go)) |-> ready_o);
endmodule

// File: tb/dac_i2c_write_rx_tb.sv
`timescale 1ns/1ps
module dac_i2c_write_rx_tb;
  localparam int NV   = 1000;
  localparam int HALF = 8;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] ADDR_W = {4'b1100, SEL, 1'b0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic sda_oe_o, ready_o;
  logic [11:0] dac_code_o;
  logic [1:0] dac_pd_o;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe_o;

  dac_i2c_write_rx #(.NV_CYCLES(NV)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .dev_sel_i(SEL), .sda_oe_o(sda_oe_o), .dac_code_o(dac_code_o),
    .dac_pd_o(dac_pd_o), .ready_o(ready_o)
  );

  // behavioural reference, advanced each rising edge
  int   h_scl[4], h_sda[4];
  int   m_phase, m_slot, m_nbits, m_val, m_cmd, m_pd, m_hi, m_rem;
  logic e_oe;
  int   e_code, e_pd;
  always @(posedge clk) begin
    int c_scl, c_sda, p_scl, p_sda;
    bit busy_now, st, sp, rise, fall, ok;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin h_scl[i] = 1; h_sda[i] = 1; end
      m_phase = 0; m_slot = 0; m_nbits = 0; m_val = 0; m_cmd = 0;
      m_pd = 0; m_hi = 0; m_rem = 0; e_oe = 0; e_code = 0; e_pd = 0;
    end else begin
      for (int i = 3; i > 0; i--) begin h_scl[i] = h_scl[i-1]; h_sda[i] = h_sda[i-1]; end
      h_scl[0] = scl_m; h_sda[0] = sda_m & ~e_oe;
      c_scl = h_scl[2]; c_sda = h_sda[2]; p_scl = h_scl[3]; p_sda = h_sda[3];
      busy_now = (m_rem > 0);
      if (m_rem > 0) m_rem--;
      st   = c_scl && p_scl && p_sda && !c_sda;
      sp   = c_scl && p_scl && !p_sda && c_sda;
      rise = c_scl && !p_scl;
      fall = !c_scl && p_scl;
      if (st) begin
        m_phase = 1; m_slot = 0; m_nbits = 0; e_oe = 0;
      end else if (sp) begin
        m_phase = 0; e_oe = 0;
      end else if (m_phase == 1) begin
        if (rise) begin
          m_val = ((m_val << 1) | c_sda) & 255; m_nbits++;
        end else if (fall && m_nbits == 8) begin
          case (m_slot)
            0: ok = ((m_val >> 1) == (96 + SEL)) && ((m_val & 1) == 0);
            1: ok = !busy_now;
            default: ok = 1;
          endcase
          if (ok && m_slot == 1) begin m_cmd = m_val >> 5; m_pd = (m_val >> 1) & 3; end
          if (ok && m_slot == 2) m_hi = m_val;
          if (ok) begin m_phase = 2; e_oe = 1; end else m_phase = 3;
        end
      end else if (m_phase == 2 && fall) begin
        e_oe = 0; m_phase = 1; m_nbits = 0;
        if (m_slot == 3) begin
          if (m_cmd == 2 || m_cmd == 3) begin
            e_code = m_hi * 16 + (m_val >> 4); e_pd = m_pd;
          end
          if (m_cmd == 3) m_rem = NV;
          m_slot = 1;
        end else m_slot++;
      end
    end
  end

  // lockstep comparison and ready-low run length
  int low_run = 0, last_low = 0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (sda_oe_o !== e_oe || dac_code_o !== 12'(e_code) ||
          dac_pd_o !== 2'(e_pd) || ready_o !== (m_rem == 0)) begin
        bad++;
        $display("FAIL R10 lockstep cyc=%0d act oe=%0b code=%h pd=%0d rdy=%0b exp oe=%0b code=%h pd=%0d rdy=%0b",
                 cyc, sda_oe_o, dac_code_o, dac_pd_o, ready_o, e_oe, e_code[11:0], e_pd, m_rem == 0);
      end
      if (!ready_o) low_run++;
      else if (low_run != 0) begin last_low = low_run; low_run = 0; end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1; bad++; total++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b0; wt(HALF); scl_m = 1'b0; wt(2);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wt(HALF); scl_m = 1'b1; wt(HALF);
    sda_m = 1'b0; wt(HALF); scl_m = 1'b0; wt(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(HALF); scl_m = 1'b1; wt(HALF); sda_m = 1'b1; wt(HALF);
  endtask

  task automatic send_byte(logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(HALF); scl_m = 1'b1; wt(HALF); scl_m = 1'b0; wt(2);
    end
    sda_m = 1'b1; wt(HALF); scl_m = 1'b1; wt(HALF / 2);
    acked = (sda_line == 1'b0);
    wt(HALF - HALF / 2); scl_m = 1'b0; wt(2);
  endtask

  task automatic group(logic [7:0] c, logic [7:0] h, logic [7:0] l,
                       string tag, bit exp_ack);
    bit a;
    send_byte(c, a); chk({tag, " cmd ack"}, a, exp_ack);
    if (exp_ack) begin
      send_byte(h, a); chk({tag, " hi ack"}, a, 1);
      send_byte(l, a); chk({tag, " lo ack"}, a, 1);
    end
  endtask

  initial begin
    bit a;
    wt(5); rst = 1'b0; wt(3);
    chk("R1 oe", sda_oe_o, 0);
    chk("R1 ready", ready_o, 1);
    chk("R1 code", dac_code_o, 0);
    chk("R1 pd", dac_pd_o, 0);

    // plain DAC write, low nibble of fourth byte set (R2 R3 R4)
    bus_start(); send_byte(ADDR_W, a); chk("R2 addr ack", a, 1);
    group(8'b010_1_1_01_1, 8'hA5, 8'hCF, "R3", 1); bus_stop();
    chk("R4 code", dac_code_o, 12'hA5C);
    chk("R3 pd", dac_pd_o, 2'b01);
    chk("R4 ready", ready_o, 1);

    // wrong strap bits and read bit are not acknowledged (R2)
    bus_start(); send_byte({4'b1100, 3'b100, 1'b0}, a); chk("R2 wrong sel", a, 0);
    send_byte(8'h40, a); chk("R2 skip cmd", a, 0); bus_stop();
    bus_start(); send_byte({4'b1100, SEL, 1'b1}, a); chk("R2 read bit", a, 0); bus_stop();
    bus_start(); send_byte({4'b1101, SEL, 1'b0}, a); chk("R2 wrong code", a, 0); bus_stop();
    chk("R2 code kept", dac_code_o, 12'hA5C);

    // write with store, then a write while busy (R5 R6)
    bus_start(); send_byte(ADDR_W, a);
    group(8'b011_0_0_10_0, 8'h3F, 8'h10, "R5", 1); wt(1);
    chk("R5 ready low", ready_o, 0);
    chk("R5 code", dac_code_o, 12'h3F1);
    chk("R5 pd", dac_pd_o, 2'b10);
    group(8'b010_0_0_11_0, 8'h12, 8'h30, "R6 repeat", 0); bus_stop();
    bus_start(); send_byte(ADDR_W, a); chk("R6 addr ack", a, 1);
    group(8'b010_0_0_11_0, 8'h12, 8'h30, "R6", 0); bus_stop();
    chk("R6 code kept", dac_code_o, 12'h3F1);
    while (!ready_o) wt(1);
    wt(2);
    chk("R5 low length", last_low, NV);

    // repeated groups without STOP (R7)
    bus_start(); send_byte(ADDR_W, a);
    group(8'b010_0_0_00_0, 8'h11, 8'h10, "R7 g1", 1); wt(2);
    chk("R7 first group", dac_code_o, 12'h111);
    group(8'b010_0_0_11_0, 8'hFF, 8'hF0, "R7 g2", 1); wt(2);
    chk("R7 second group", dac_code_o, 12'hFFF);
    chk("R7 pd", dac_pd_o, 2'b11); bus_stop();

    // unknown commands are taken but discarded (R8)
    bus_start(); send_byte(ADDR_W, a);
    group(8'b000_0_0_01_0, 8'h22, 8'h20, "R8 c000", 1);
    group(8'b110_0_0_01_0, 8'h33, 8'h30, "R8 c110", 1); bus_stop();
    chk("R8 code", dac_code_o, 12'hFFF);
    chk("R8 pd", dac_pd_o, 2'b11);
    chk("R8 ready", ready_o, 1);

    // partial groups aborted by repeated START and by STOP (R9)
    bus_start(); send_byte(ADDR_W, a);
    send_byte(8'b010_0_0_00_0, a); send_byte(8'h55, a);
    bus_rstart(); send_byte(8'h55, a); chk("R9 rstart needs addr", a, 0);
    bus_rstart(); send_byte(ADDR_W, a); chk("R9 addr after rstart", a, 1);
    send_byte(8'b010_0_0_00_0, a); send_byte(8'h66, a); bus_stop();
    chk("R9 code kept", dac_code_o, 12'hFFF);
    bus_start(); send_byte(ADDR_W, a);
    group(8'b010_0_0_01_0, 8'h7E, 8'h50, "R9 fresh", 1); bus_stop();
    chk("R9 fresh code", dac_code_o, 12'h7E5);

    wt(10);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule